// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block is an eight-pin general-purpose I/O port. A small processor reaches it through a simple register bus. The bus has a 3-bit address, a write strobe, write data and combinational read data. Inside the block are four per-pin registers:

- a direction register;
- an output data latch;
- an analog-select register;
- a pull-up enable register.

Every pin connects to a pad through three signals: an output value, an output enable and a raw input level. The raw input passes through a synchronizer before any read can see it.

Two separate bus addresses write the same output latch, but they read back different things. One address returns the synchronized pin levels. The other returns the latch itself. Because of this, software can do read-modify-write through the latch address without picking up pin levels.

Selecting analog mode on a pin does two things: it raises that pin's digital-input-disable control, and it forces the pin's bit in the level read to zero. An on-chip peripheral can take over a pin's output value and output enable. While it does so, the pin's level can still be read.

Top module: `gpio_port`

## Requirements
- R1: After synchronous reset, the register state is as follows, so every `pad_oe` bit is 0 when no peripheral override is active:

  | Register | Reset value |
  |---|---|
  | direction | 0xFF (all inputs) |
  | output latch | 0x00 |
  | analog select | 0xFF |
  | pull-up enable | 0x00 |

- R2: A write with `bus_we` high to address 0 (pin level) or to address 1 (output latch) loads `bus_wdata` into the output latch at the next clock edge. A read of address 1 returns the latch contents.
- R3: A read of address 0 returns each pin's input level after a two-flop synchronizer. A pad change seen before one rising edge is not visible after that edge, and it is visible after the second edge.
- R4: For each bit set in the analog-select register (address 3), `din_disable` is 1 and the address-0 read of that bit returns 0.
- R5: With no peripheral override on a pin, a direction bit (address 2) of 0 sets `pad_oe` to 1 and drives `pad_out` from the latch bit. A direction bit of 1 clears `pad_oe`.
- R6: When a bit of `periph_en` is 1, that pin's `pad_out` and `pad_oe` follow `periph_out` and `periph_oe`, whatever the latch and direction hold. The pin's level stays readable at address 0.
- R7: The pull-up enable register (address 4) drives `pull_en` bit for bit.
- R8: Addresses 2, 3 and 4 read back the direction, analog-select and pull-up registers. Addresses 5 to 7 read 0, and writes to them change no register.
- R9: No register changes in a cycle where `bus_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| periph_en | input | 8 | Per-pin peripheral takeover |
| periph_out | input | 8 | Peripheral output values |
| periph_oe | input | 8 | Peripheral output enables |
| pull_en | output | 8 | Weak pull-up enables |
| din_disable | output | 8 | Digital input buffer disables |

## Verification
The bench builds the block with its default parameters: eight pins and a two-stage synchronizer. With these values the exact read latency can be pinned down by sampling once after a single edge and again after the second edge. Mixed direction, analog and override patterns across the eight bits let one stimulus show, side by side, pins that are driven, pins that are gated off and pins that are taken over by the peripheral.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PIN    = 3'd0,
        SEL_LATCH  = 3'd1,
        SEL_DIR    = 3'd2,
        SEL_ANALOG = 3'd3,
        SEL_PULL   = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] latch;
        logic [PORT_W-1:0] analog;
        logic [PORT_W-1:0] pull;
    } port_cfg_t;

    localparam port_cfg_t CFG_RESET = '{
        dir:    {PORT_W{1'b1}},
        latch:  {PORT_W{1'b0}},
        analog: {PORT_W{1'b1}},
        pull:   {PORT_W{1'b0}}
    };

    function automatic logic addr_hits_latch(input logic [ADDR_W-1:0] a);
        return (a == SEL_PIN) || (a == SEL_LATCH);
    endfunction
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PORT_W-1:0] bus_wdata,
    input  logic [PORT_W-1:0] pin_sync,
    output logic [PORT_W-1:0] bus_rdata,
    output port_cfg_t         cfg
);
    port_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (bus_we) begin
            if (addr_hits_latch(bus_addr)) cfg_q.latch  <= bus_wdata;
            if (bus_addr == SEL_DIR)       cfg_q.dir    <= bus_wdata;
            if (bus_addr == SEL_ANALOG)    cfg_q.analog <= bus_wdata;
            if (bus_addr == SEL_PULL)      cfg_q.pull   <= bus_wdata;
        end
    end

    always_comb begin
        case (bus_addr)
            SEL_PIN:    bus_rdata = pin_sync & ~cfg_q.analog;
            SEL_LATCH:  bus_rdata = cfg_q.latch;
            SEL_DIR:    bus_rdata = cfg_q.dir;
            SEL_ANALOG: bus_rdata = cfg_q.analog;
            SEL_PULL:   bus_rdata = cfg_q.pull;
            default:    bus_rdata = '0;
        endcase
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/gpio_port_pad.sv
module gpio_port_pad #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] latch,
    input  logic [WIDTH-1:0] periph_en,
    input  logic [WIDTH-1:0] periph_out,
    input  logic [WIDTH-1:0] periph_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            if (periph_en[i]) begin
                pad_out[i] = periph_out[i];
                pad_oe[i]  = periph_oe[i];
            end else begin
                pad_out[i] = latch[i];
                pad_oe[i]  = ~dir[i];
            end
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    input  logic [PORT_W-1:0] periph_en,
    input  logic [PORT_W-1:0] periph_out,
    input  logic [PORT_W-1:0] periph_oe,
    output logic [PORT_W-1:0] pull_en,
    output logic [PORT_W-1:0] din_disable
);
    port_cfg_t         cfg;
    logic [PORT_W-1:0] pin_sync;

    gpio_port_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_sync)
    );

    gpio_port_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .pin_sync  (pin_sync),
        .bus_rdata (bus_rdata),
        .cfg       (cfg)
    );

    gpio_port_pad #(.WIDTH(PORT_W)) u_pad (
        .dir        (cfg.dir),
        .latch      (cfg.latch),
        .periph_en  (periph_en),
        .periph_out (periph_out),
        .periph_oe  (periph_oe),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    assign pull_en     = cfg.pull;
    assign din_disable = cfg.analog;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [PORT_W-1:0] bus_wdata,
    input logic [PORT_W-1:0] bus_rdata,
    input logic [PORT_W-1:0] pad_oe,
    input logic [PORT_W-1:0] pad_out,
    input logic [PORT_W-1:0] periph_en,
    input logic [PORT_W-1:0] periph_out,
    input logic [PORT_W-1:0] din_disable,
    input port_cfg_t         cfg
);
    // R1
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg == CFG_RESET));

    // R2
    a_r2_latch_load: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr <= 3'd1) |=> (cfg.latch == $past(bus_wdata)));

    // R4
    a_r4_analog_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd0) |-> ((bus_rdata & din_disable) == '0));

    // R5
    a_r5_input_undriven: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & ~periph_en & cfg.dir) == '0));

    // R6
    a_r6_periph_value: assert property (@(posedge clk) disable iff (rst)
        (((pad_out ^ periph_out) & periph_en) == '0));

    // R8
    a_r8_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr >= 3'd5) |-> (bus_rdata == '0));

    // R9
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> $stable(cfg));
endmodule

bind gpio_port gpio_port_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .periph_en   (periph_en),
    .periph_out  (periph_out),
    .din_disable (din_disable),
    .cfg         (cfg)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe, pull_en, din_disable;
    logic [7:0] periph_en = '0, periph_out = '0, periph_oe = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_port u_dut (
        .clk (clk), .rst (rst),
        .bus_addr (bus_addr), .bus_we (bus_we),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .pad_in (pad_in), .pad_out (pad_out), .pad_oe (pad_oe),
        .periph_en (periph_en), .periph_out (periph_out),
        .periph_oe (periph_oe), .pull_en (pull_en),
        .din_disable (din_disable)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 din_disable", din_disable, 8'hFF);
        chk("R1 pull_en", pull_en, 8'h00);
        rd(3'd2, v); chk("R1 dir", v, 8'hFF);
        rd(3'd1, v); chk("R1 latch", v, 8'h00);
    endtask

    task automatic t_latch();
        logic [7:0] v;
        wr(3'd0, 8'hA5); rd(3'd1, v); chk("R2 write via pin addr", v, 8'hA5);
        wr(3'd1, 8'h3C); rd(3'd1, v); chk("R2 write via latch addr", v, 8'h3C);
        wr(3'd1, v | 8'h40); rd(3'd1, v); chk("R2 read-modify-write", v, 8'h7C);
        wr(3'd1, 8'h3C);
    endtask

    task automatic t_dir();
        wr(3'd2, 8'hF0);
        chk("R5 pad_oe", pad_oe, 8'h0F);
        chk("R5 pad_out", pad_out & 8'h0F, 8'h0C);
    endtask

    task automatic t_sync_analog();
        logic [7:0] v;
        wr(3'd3, 8'h00);
        @(negedge clk); pad_in = 8'h96;
        @(negedge clk); rd(3'd0, v); chk("R3 one edge, not yet visible", v, 8'h00);
        @(negedge clk); rd(3'd0, v); chk("R3 two edges, visible", v, 8'h96);
        rd(3'd1, v); chk("R2 latch read ignores pins", v, 8'h3C);
        wr(3'd3, 8'h0F);
        rd(3'd0, v); chk("R4 analog bits read zero", v, 8'h90);
        chk("R4 din_disable", din_disable, 8'h0F);
    endtask

    task automatic t_periph();
        logic [7:0] v;
        @(negedge clk);
        periph_en = 8'h81; periph_out = 8'h01; periph_oe = 8'h80;
        #1;
        chk("R6 pad_oe override", pad_oe, 8'h8E);
        chk("R6 pad_out override", pad_out, 8'h3D);
        rd(3'd0, v); chk("R6 pin still readable", v, 8'h90);
        @(negedge clk);
        periph_en = 8'h00;
        #1;
        chk("R6 release restores", pad_oe, 8'h0F);
    endtask

    task automatic t_pull();
        logic [7:0] v;
        wr(3'd4, 8'h5A);
        chk("R7 pull_en", pull_en, 8'h5A);
        rd(3'd4, v); chk("R8 pull readback", v, 8'h5A);
        rd(3'd3, v); chk("R8 analog readback", v, 8'h0F);
    endtask

    task automatic t_unused();
        logic [7:0] v;
        wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), v); chk("R8 unused reads zero", v, 8'h00);
        end
        rd(3'd1, v); chk("R8 latch untouched", v, 8'h3C);
        rd(3'd2, v); chk("R8 dir untouched", v, 8'hF0);
        chk("R8 pull untouched", pull_en, 8'h5A);
        chk("R8 analog untouched", din_disable, 8'h0F);
    endtask

    task automatic t_no_we();
        logic [7:0] v;
        @(negedge clk);
        bus_addr = 3'd1; bus_wdata = 8'h00; bus_we = 1'b0;
        @(negedge clk);
        bus_addr = 3'd2;
        @(negedge clk);
        rd(3'd1, v); chk("R9 latch held", v, 8'h3C);
        rd(3'd2, v); chk("R9 dir held", v, 8'hF0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_latch();
        t_dir();
        t_sync_analog();
        t_periph();
        t_pull();
        t_unused();
        t_no_we();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule